// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Write Buffer

This block is a direct-mapped data cache for a 32-bit physical address space, with one 32-bit word per line. A load that hits returns the stored word in the cycle it is presented. A load that misses reads exactly one word from memory, fills the line and then returns it. Before that read is issued, every store still held in the write buffer is drained to memory, so the refill can never return stale memory contents.

Every store is written through to memory. A store that hits also updates the cached word. A store that misses leaves the cache untouched. In both cases the store is queued in a four-entry posted write buffer, which retires entries to a slower memory write port in order and independently of the processor. The processor stalls on a store only when that buffer is full.

Each line carries one parity bit over its tag and one over its data. Both are generated when the line is written and checked on every lookup, and a mismatch is treated exactly like a miss. A separate invalidate port lets another bus master, such as a DMA engine writing memory, clear the line whose tag matches the address it presents. Capacity defaults to 4 kB and can be set to 8 kB by a parameter.

Top module: `wt_dcache`

## Requirements
- R1: The word index is `cpu_addr[IDX_W+1:2]` and the tag is `cpu_addr[31:IDX_W+2]`, with IDX_W = log2(CAP_BYTES/4). That gives 10 index bits at the 4 kB default and 11 at 8 kB. Two addresses that share an index but differ in tag evict each other.
- R2: A load (`cpu_req`=1, `cpu_we`=0) that hits a valid line with matching tag and correct parity keeps `cpu_stall` at 0 and drives the stored word on `cpu_rdata` in the same cycle. It starts no memory read.
- R3: A load miss holds `cpu_stall` at 1 and issues one memory read, with `mem_rd_addr` = `cpu_addr`. On `mem_rd_ack` the word is filled, and in the following cycle the load completes as a hit.
- R4: `mem_rd_req` is never asserted while the write buffer holds an entry, so a load miss waits for all posted stores to reach memory.
- R5: Every accepted store (`cpu_we`=1, `cpu_stall`=0) is written to memory through `mem_wr_*` in acceptance order. A store hit also updates the cached word, so the next load returns the new value.
- R6: A store miss allocates no line, and a later load of that address misses.
- R7: The write buffer holds 4 entries (WB_DEPTH). A store stalls only when all 4 are occupied, and is accepted once memory acknowledges a write.
- R8: Once asserted, `mem_wr_req` holds with stable address and data until `mem_wr_ack`, and `mem_rd_req` holds until `mem_rd_ack`.
- R9: A parity mismatch on lookup is a miss. The word is fetched again from memory and the load returns correct data. `fill_par_flip`=1 during the fill acknowledge cycle stores inverted data parity (a fault-injection hook).
- R10: An `inv_valid` pulse clears the line indexed by `inv_addr` only when its stored tag equals the tag of `inv_addr`. A mismatching tag leaves the line valid.
- R11: After reset `cpu_stall`, `mem_rd_req` and `mem_wr_req` are 0 and no line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until not stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when not stalled |
| cpu_stall | output | 1 | Access not accepted this cycle |
| mem_rd_req | output | 1 | Single-word memory read request |
| mem_rd_addr | output | 32 | Read address |
| mem_rd_ack | input | 1 | Read data valid, ends the read |
| mem_rd_data | input | 32 | Read data |
| fill_par_flip | input | 1 | Fault injection: invert stored data parity on this fill |
| mem_wr_req | output | 1 | Write buffer head valid |
| mem_wr_addr | output | 32 | Head store address |
| mem_wr_data | output | 32 | Head store data |
| mem_wr_ack | input | 1 | Memory took the head store |
| inv_valid | input | 1 | Invalidate strobe from another bus master |
| inv_addr | input | 32 | Address to invalidate |

## Verification
The hardest situations to reach are a load miss arriving while posted stores are still queued, and a line whose stored parity is wrong. The bench's memory model can hold off write acknowledges. This lets it fill the buffer, observe the stall on the fifth store, and then launch a concurrent load miss that must not raise `mem_rd_req` until the writes are released. For parity, the model raises `fill_par_flip` on one chosen refill acknowledge only. The load must then cost exactly two memory reads and still return the correct word.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_DRAIN = 2'd1,
    CS_FILL  = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/dc_wbuf.sv
module dc_wbuf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  output logic              full,
  output logic              empty,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pop;

  assign full    = (cnt_q == FULLC);
  assign empty   = (cnt_q == '0);
  assign wr_req  = !empty;
  assign wr_addr = addr_q[rp_q];
  assign wr_data = data_q[rp_q];
  assign pop     = wr_req && wr_ack;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wp_q] <= push_addr;
      data_q[wp_q] <= push_data;
    end
  end

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
endmodule

// File: rtl/dc_array.sv
module dc_array #(
  parameter int WADDR_W = 30,
  parameter int DATA_W  = 32,
  parameter int LINES   = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WADDR_W-1:0] lk_waddr,
  output logic               lk_hit,
  output logic [DATA_W-1:0]  lk_data,
  input  logic               fill_we,
  input  logic [DATA_W-1:0]  fill_data,
  input  logic               fill_par_flip,
  input  logic               st_we,
  input  logic [DATA_W-1:0]  st_data,
  input  logic               inv_valid,
  input  logic [WADDR_W-1:0] inv_waddr
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = WADDR_W - IDX_W;

  logic              vld_q  [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic              tpar_q [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic              dpar_q [LINES];

  logic [IDX_W-1:0]  lk_idx, inv_idx;
  logic [TAG_W-1:0]  lk_tag, inv_tag;
  logic              par_ok, wr_en, inv_clr;
  logic [DATA_W-1:0] wr_data;

  assign lk_idx  = lk_waddr[IDX_W-1:0];
  assign lk_tag  = lk_waddr[WADDR_W-1:IDX_W];
  assign inv_idx = inv_waddr[IDX_W-1:0];
  assign inv_tag = inv_waddr[WADDR_W-1:IDX_W];

  assign lk_data = data_q[lk_idx];
  assign par_ok  = ((^tag_q[lk_idx]) == tpar_q[lk_idx]) &&
                   ((^data_q[lk_idx]) == dpar_q[lk_idx]);
  assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag) && par_ok;

  assign wr_en   = fill_we || st_we;
  assign wr_data = fill_we ? fill_data : st_data;

  always_comb begin
    inv_clr = 1'b0;
    if (inv_valid) begin
      if (vld_q[inv_idx] && (tag_q[inv_idx] == inv_tag)) inv_clr = 1'b1;
      if (fill_we && (inv_idx == lk_idx) && (inv_tag == lk_tag)) inv_clr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) vld_q[i] <= 1'b0;
    end else begin
      if (fill_we) vld_q[lk_idx] <= 1'b1;
      if (inv_clr) vld_q[inv_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_q[lk_idx] <= wr_data;
      dpar_q[lk_idx] <= (^wr_data) ^ (fill_we && fill_par_flip);
    end
    if (fill_we) begin
      tag_q[lk_idx]  <= lk_tag;
      tpar_q[lk_idx] <= ^lk_tag;
    end
  end

  // R10
  inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_clr |=> !vld_q[$past(inv_idx)]);
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld_miss,
  input  logic wb_empty,
  input  logic mem_rd_ack,
  output logic mem_rd_req,
  output logic fill_we
);
  ctl_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CS_IDLE:  if (ld_miss) st_d = wb_empty ? CS_FILL : CS_DRAIN;
      CS_DRAIN: if (wb_empty) st_d = CS_FILL;
      CS_FILL:  if (mem_rd_ack) st_d = CS_IDLE;
      default:  st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CS_IDLE;
    else        st_q <= st_d;
  end

  assign mem_rd_req = (st_q == CS_FILL);
  assign fill_we    = mem_rd_req && mem_rd_ack;

  // R4
  rd_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> wb_empty);
  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> mem_rd_req);
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CAP_BYTES = 4096,
  parameter int WB_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              fill_par_flip,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr
);
  localparam int LINES   = CAP_BYTES / (DATA_W / 8);
  localparam int WADDR_W = ADDR_W - 2;

  logic rst_s1_q, rst_s2_q;
  logic lk_hit, wb_full, wb_empty, ld_miss, st_ok, st_hit, fill_we;
  logic unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  assign ld_miss     = cpu_req && !cpu_we && !lk_hit;
  assign st_ok       = cpu_req && cpu_we && !wb_full;
  assign st_hit      = st_ok && lk_hit;
  assign cpu_stall   = cpu_req && (cpu_we ? wb_full : !lk_hit);
  assign mem_rd_addr = cpu_addr;
  assign unused_bits = ^inv_addr[1:0];

  dc_array #(.WADDR_W(WADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_array (
    .clk(clk), .rst_n(rst_s2_q),
    .lk_waddr(cpu_addr[ADDR_W-1:2]), .lk_hit(lk_hit), .lk_data(cpu_rdata),
    .fill_we(fill_we), .fill_data(mem_rd_data), .fill_par_flip(fill_par_flip),
    .st_we(st_hit), .st_data(cpu_wdata),
    .inv_valid(inv_valid), .inv_waddr(inv_addr[ADDR_W-1:2])
  );

  dc_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk(clk), .rst_n(rst_s2_q),
    .push(st_ok), .push_addr(cpu_addr), .push_data(cpu_wdata),
    .full(wb_full), .empty(wb_empty),
    .wr_req(mem_wr_req), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data),
    .wr_ack(mem_wr_ack)
  );

  dc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_s2_q),
    .ld_miss(ld_miss), .wb_empty(wb_empty), .mem_rd_ack(mem_rd_ack),
    .mem_rd_req(mem_rd_req), .fill_we(fill_we)
  );

  // R2
  hit_no_read_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (cpu_req && !cpu_we && !cpu_stall) |-> !mem_rd_req);
endmodule

// File: tb/wt_dcache_bench.sv
module wt_dcache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_rd_req, mem_wr_req;
  logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
  logic        mem_rd_ack = 1'b0, mem_wr_ack = 1'b0, fill_par_flip = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        inv_valid = 1'b0;
  logic [31:0] inv_addr = '0;

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0;
  bit wr_hold = 1'b0, flip_arm = 1'b0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] wr_log [64];

  always #2.5 clk = ~clk;

  wt_dcache u_wt_dcache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_data(mem_rd_data), .fill_par_flip(fill_par_flip),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack), .inv_valid(inv_valid), .inv_addr(inv_addr)
  );

  function automatic logic [31:0] mem_get(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model: read latency 3, write latency 2 (unless held)
  initial begin
    int rl = 0, wl = 0;
    forever begin
      @(negedge clk);
      if (mem_rd_ack) begin
        mem_rd_ack = 1'b0;
        fill_par_flip = 1'b0;
      end else if (mem_rd_req) begin
        rl++;
        if (rl == 3) begin
          rl = 0;
          mem_rd_data = mem_get(mem_rd_addr);
          mem_rd_ack = 1'b1;
          fill_par_flip = flip_arm;
          flip_arm = 1'b0;
          rd_cnt++;
        end
      end
      if (mem_wr_ack) begin
        mem_wr_ack = 1'b0;
      end else if (mem_wr_req && !wr_hold) begin
        wl++;
        if (wl == 2) begin
          wl = 0;
          mem[mem_wr_addr] = mem_wr_data;
          if (wr_cnt < 64) wr_log[wr_cnt] = mem_wr_addr;
          wr_cnt++;
          mem_wr_ack = 1'b1;
        end
      end
    end
  end

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int stalls);
    stalls = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #0.5;
    while (cpu_stall) begin
      stalls++;
      @(negedge clk);
      #0.5;
    end
    rd = cpu_rdata;
    @(posedge clk);
    #0.5;
    cpu_req = 1'b0;
  endtask

  task automatic inv_pulse(input logic [31:0] a);
    @(negedge clk);
    inv_valid = 1'b1; inv_addr = a;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic drain();
    while (mem_wr_req) @(negedge clk);
    @(negedge clk);
  endtask

  // {we, addr, wdata, expected rdata, expected memory reads}
  localparam int NV = 9;
  localparam logic [97:0] VEC [NV] = '{
    {1'b0, 32'h0000_0100, 32'h0, 32'h5A5A_0100, 1'b1},  // R3 miss
    {1'b0, 32'h0000_0100, 32'h0, 32'h5A5A_0100, 1'b0},  // R2 hit
    {1'b1, 32'h0000_0100, 32'h1111_2222, 32'h0, 1'b0},  // R5 store hit
    {1'b0, 32'h0000_0100, 32'h0, 32'h1111_2222, 1'b0},  // R5 updated word
    {1'b0, 32'h0000_1100, 32'h0, 32'h5A5A_1100, 1'b1},  // R1 same index, other tag
    {1'b0, 32'h0000_0100, 32'h0, 32'h1111_2222, 1'b1},  // R1 evicted; R5 written through
    {1'b1, 32'h0000_2200, 32'hCAFE_F00D, 32'h0, 1'b0},  // R6 store miss
    {1'b0, 32'h0000_2200, 32'h0, 32'hCAFE_F00D, 1'b1},  // R6 no allocate
    {1'b0, 32'h0000_2200, 32'h0, 32'hCAFE_F00D, 1'b0}   // R2 hit after fill
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int st, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(cpu_stall == 1'b0, "R11 stall", {31'b0, cpu_stall}, 32'h0);
    chk(mem_rd_req == 1'b0, "R11 rd_req", {31'b0, mem_rd_req}, 32'h0);
    chk(mem_wr_req == 1'b0, "R11 wr_req", {31'b0, mem_wr_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      r0 = rd_cnt;
      access(VEC[i][97], VEC[i][96:65], VEC[i][64:33], rd, st);
      if (!VEC[i][97])
        chk(rd == VEC[i][32:1], $sformatf("R2/R3 row %0d data", i), rd, VEC[i][32:1]);
      chk((rd_cnt - r0) == int'(VEC[i][0]), $sformatf("R3 row %0d reads", i),
          32'(rd_cnt - r0), {31'b0, VEC[i][0]});
    end
    drain();

    // R7 four stores accepted without stall while writes are held
    wr_hold = 1'b1;
    r0 = wr_cnt;
    for (int k = 0; k < 4; k++) begin
      access(1'b1, 32'h0000_0500 + 32'(4 * k), 32'hA000_0000 + 32'(k), rd, st);
      chk(st == 0, "R7 store no stall", 32'(st), 32'h0);
    end
    fork
      access(1'b1, 32'h0000_0510, 32'hA000_0004, rd, st);
      begin
        repeat (3) @(negedge clk);
        #0.5;
        chk(cpu_stall == 1'b1, "R7 fifth store stalls", {31'b0, cpu_stall}, 32'h1);
        wr_hold = 1'b0;
      end
    join
    drain();
    // R5 write order
    for (int k = 0; k < 5; k++)
      chk(wr_log[r0 + k] == 32'h0000_0500 + 32'(4 * k), "R5 write order",
          wr_log[r0 + k], 32'h0000_0500 + 32'(4 * k));

    // R4 load miss waits for buffer drain
    wr_hold = 1'b1;
    access(1'b1, 32'h0000_0600, 32'h6666_0000, rd, st);
    r0 = rd_cnt;
    fork
      access(1'b0, 32'h0000_0604, 32'h0, rd, st);
      begin
        repeat (8) @(negedge clk);
        chk(mem_rd_req == 1'b0 && rd_cnt == r0, "R4 no read while buffered",
            {31'b0, mem_rd_req}, 32'h0);
        wr_hold = 1'b0;
      end
    join
    chk(rd == 32'h5A5A_0604, "R4 load after drain", rd, 32'h5A5A_0604);
    access(1'b0, 32'h0000_0508, 32'h0, rd, st);
    chk(rd == 32'hA000_0002, "R6 R5 stored word from memory", rd, 32'hA000_0002);

    // R10 invalidate
    access(1'b0, 32'h0000_0700, 32'h0, rd, st);
    inv_pulse(32'h0000_1700);
    r0 = rd_cnt;
    access(1'b0, 32'h0000_0700, 32'h0, rd, st);
    chk(rd_cnt == r0, "R10 tag mismatch keeps line", 32'(rd_cnt - r0), 32'h0);
    inv_pulse(32'h0000_0700);
    mem[32'h0000_0700] = 32'hD0A0_0700;
    r0 = rd_cnt;
    access(1'b0, 32'h0000_0700, 32'h0, rd, st);
    chk(rd_cnt - r0 == 1, "R10 invalidated line refetched", 32'(rd_cnt - r0), 32'h1);
    chk(rd == 32'hD0A0_0700, "R10 new memory value", rd, 32'hD0A0_0700);

    // R9 parity fault on fill treated as miss
    flip_arm = 1'b1;
    r0 = rd_cnt;
    access(1'b0, 32'h0000_0800, 32'h0, rd, st);
    chk(rd_cnt - r0 == 2, "R9 parity miss reads twice", 32'(rd_cnt - r0), 32'h2);
    chk(rd == 32'h5A5A_0800, "R9 data", rd, 32'h5A5A_0800);
    r0 = rd_cnt;
    access(1'b0, 32'h0000_0800, 32'h0, rd, st);
    chk(rd_cnt == r0, "R9 clean refill hits", 32'(rd_cnt - r0), 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule